// File: doc/BRIEF.md
# SDRAM Command Timing Checker

A passive monitor for a synchronous DRAM command bus with two internal banks. Each clock it decodes chip select, the three strobes, the bank address and the A10 line. It keeps an open or closed flag for each bank and counts the cycles since the commands that the spacing rules depend on. It also counts refresh commands in a fixed window of cycles. The block never drives the bus. It is placed beside a memory controller in simulation or on silicon, to catch controller bugs.

The first rule broken sets a sticky error output. It also latches an 8-bit one-hot code that names the rule. A synchronous clear input returns all error flags, bank flags, spacing counters and the refresh window to their reset state. All spacing minima, the number of banks, the window length and the required refresh count are parameters. The window can therefore be shortened for simulation.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With cs_n low, the command is decoded from {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop, 111 no-op. With cs_n high the bus is ignored. No-op and deselect never count as a command.
- R2: A read or write to an open bank fewer than T_RCD (3) cycles after that bank's activate sets code bit 0.
- R3: An activate fewer than T_RP (3) cycles after that bank was closed sets code bit 1. The bank may have been closed by a precharge or by an auto-close.
- R4: A precharge of an open bank fewer than T_RAS (6) cycles after its activate sets code bit 2.
- R5: An activate fewer than T_RC (9) cycles after the previous activate of the same bank sets code bit 3.
- R6: An activate to a different bank fewer than T_RRD (2) cycles after the last activate sets code bit 4.
- R7: Any command fewer than T_MRD (2) cycles after a mode set sets code bit 5.
- R8: Any of the following sets code bit 6: a read or write to a closed bank, an activate to an open bank, or a refresh or mode set while any bank is open.
- R9: A precharge with A10 high closes every bank. A read or write with A10 high closes its bank in the same cycle, and that cycle starts the bank's T_RP count.
- R10: At the last cycle of each REF_WINDOW-cycle window, fewer than REF_MIN refreshes within that window sets code bit 7.
- R11: err is sticky. viol_code is one-hot and holds the first error. When several rules break in the same cycle, the lowest bit wins.
- R12: A clr cycle returns err, viol_code, all bank flags, all counters and the refresh window to their reset state.
- R13: After reset, err is 0, viol_code is 0 and every bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all checker state |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Precharge-all / auto-close flag |
| err | output | 1 | Sticky error flag |
| viol_code | output | 8 | One-hot code of the first broken rule |

## Verification
A wrong bank flag or elapsed count inside the block appears at err and viol_code on the clock edge that samples the next command touching that bank. A flag or count that is too permissive leaves err low where the bench expects a code. One that is too strict raises the wrong bit. Each spacing rule is swept across its threshold, one cycle below to one cycle above. Those sweeps expose off-by-one count errors within one command. A wrong refresh count only shows at the end of the window, about REF_WINDOW cycles after the last clear.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF,
      CMD_MRS,
      CMD_BST
   } cmd_e;

   localparam int unsigned NUM_VIOL = 8;
   localparam int unsigned V_RCD    = 0;
   localparam int unsigned V_RP     = 1;
   localparam int unsigned V_RAS    = 2;
   localparam int unsigned V_RC     = 3;
   localparam int unsigned V_RRD    = 4;
   localparam int unsigned V_MRD    = 5;
   localparam int unsigned V_STATE  = 6;
   localparam int unsigned V_STARVE = 7;

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_chk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_NONE;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MRS;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sdram_elapsed_ctr.sv
module sdram_elapsed_ctr #(
   parameter  int unsigned MAX_CNT = 9,
   localparam int unsigned W       = $clog2(MAX_CNT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         start,
   output logic [W-1:0] count
);

   // Saturated value means "no event seen yet" and satisfies every minimum.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= W'(MAX_CNT);
      end else if (clr) begin
         count <= W'(MAX_CNT);
      end else if (start) begin
         count <= W'(1);
      end else if (count < W'(MAX_CNT)) begin
         count <= count + W'(1);
      end
   end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
   import sdram_chk_pkg::*;
#(
   parameter int unsigned T_RCD = 3,
   parameter int unsigned T_RP  = 3,
   parameter int unsigned T_RAS = 6,
   parameter int unsigned T_RC  = 9,
   parameter int unsigned T_MAX = 9,
   localparam int unsigned CW   = $clog2(T_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  cmd_e                cmd,
   input  logic                sel,
   input  logic                a10,
   output logic                is_open,
   output logic [NUM_VIOL-1:0] viol
);

   logic          act_hit, rw_hit, pre_hit, close_now;
   logic [CW-1:0] since_act, since_close;

   assign act_hit   = (cmd == CMD_ACT) && sel;
   assign rw_hit    = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel;
   assign pre_hit   = (cmd == CMD_PRE) && (sel || a10);
   assign close_now = is_open && (pre_hit || (rw_hit && a10));

   sdram_elapsed_ctr #(.MAX_CNT(T_MAX)) u_act_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .start (act_hit),
      .count (since_act)
   );

   sdram_elapsed_ctr #(.MAX_CNT(T_MAX)) u_close_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .start (close_now),
      .count (since_close)
   );

   always_comb begin
      viol          = '0;
      viol[V_RCD]   = rw_hit && is_open && (since_act < CW'(T_RCD));
      viol[V_RP]    = act_hit && (since_close < CW'(T_RP));
      viol[V_RAS]   = pre_hit && is_open && (since_act < CW'(T_RAS));
      viol[V_RC]    = act_hit && (since_act < CW'(T_RC));
      viol[V_STATE] = (rw_hit && !is_open) || (act_hit && is_open);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open <= 1'b0;
      end else if (clr) begin
         is_open <= 1'b0;
      end else if (act_hit) begin
         is_open <= 1'b1;
      end else if (close_now) begin
         is_open <= 1'b0;
      end
   end

   assert_open_after_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_hit && !clr) |=> is_open);

   assert_close_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == CMD_PRE) && a10 && !clr) |=> !is_open);

endmodule

// File: rtl/sdram_refresh_window.sv
module sdram_refresh_window #(
   parameter  int unsigned WINDOW   = 8533333,
   parameter  int unsigned MIN_REFS = 4096,
   localparam int unsigned WW       = (WINDOW > 1) ? $clog2(WINDOW) : 1,
   localparam int unsigned RW       = $clog2(MIN_REFS + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ref_now,
   output logic starve
);

   logic [WW-1:0] win_cnt;
   logic [RW-1:0] ref_cnt, ref_total;
   logic          at_end;

   assign at_end    = (win_cnt == WW'(WINDOW - 1));
   assign ref_total = ref_cnt + RW'(ref_now);
   assign starve    = at_end && (ref_total < RW'(MIN_REFS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         ref_cnt <= '0;
      end else if (clr || at_end) begin
         win_cnt <= '0;
         ref_cnt <= '0;
      end else begin
         win_cnt <= win_cnt + WW'(1);
         if (ref_now && (ref_cnt < RW'(MIN_REFS))) begin
            ref_cnt <= ref_cnt + RW'(1);
         end
      end
   end

   assert_starve_wraps_R10: assert property (@(posedge clk) disable iff (!rst_n)
      starve |=> (win_cnt == '0) && (ref_cnt == '0));

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
   import sdram_chk_pkg::*;
#(
   parameter  int unsigned NUM_BANKS  = 2,
   parameter  int unsigned T_RCD      = 3,
   parameter  int unsigned T_RP       = 3,
   parameter  int unsigned T_RAS      = 6,
   parameter  int unsigned T_RC       = 9,
   parameter  int unsigned T_RRD      = 2,
   parameter  int unsigned T_MRD      = 2,
   parameter  int unsigned REF_WINDOW = 8533333,
   parameter  int unsigned REF_MIN    = 4096,
   localparam int unsigned BA_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                cs_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic [BA_W-1:0]     ba,
   input  logic                a10,
   output logic                err,
   output logic [NUM_VIOL-1:0] viol_code
);

   localparam int unsigned T_MAX = max2(max2(max2(T_RCD, T_RP), max2(T_RAS, T_RC)),
                                        max2(T_RRD, T_MRD));
   localparam int unsigned CW    = $clog2(T_MAX + 1);

   // Elaboration-time parameter checks
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RAS < 1 || T_RC < 1 || T_RRD < 1 || T_MRD < 1) begin : g_bad_t
      $error("every spacing minimum must be at least 1");
   end
   if (REF_WINDOW < 2 || REF_MIN < 1) begin : g_bad_ref
      $error("REF_WINDOW must be >= 2 and REF_MIN >= 1");
   end

   cmd_e                cmd;
   logic                is_cmd, any_open, starve;
   logic [NUM_BANKS-1:0] bank_open;
   logic [NUM_VIOL-1:0] bank_viol [NUM_BANKS];
   logic [NUM_VIOL-1:0] viol_vec, first_viol;
   logic [CW-1:0]       since_any_act, since_mrs;
   logic [BA_W-1:0]     last_act_ba;

   sdram_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign is_cmd = (cmd != CMD_NONE);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdram_bank_tracker #(
         .T_RCD (T_RCD),
         .T_RP  (T_RP),
         .T_RAS (T_RAS),
         .T_RC  (T_RC),
         .T_MAX (T_MAX)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .cmd     (cmd),
         .sel     (ba == BA_W'(b)),
         .a10     (a10),
         .is_open (bank_open[b]),
         .viol    (bank_viol[b])
      );
   end

   assign any_open = |bank_open;

   sdram_elapsed_ctr #(.MAX_CNT(T_MAX)) u_rrd_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .start (cmd == CMD_ACT),
      .count (since_any_act)
   );

   sdram_elapsed_ctr #(.MAX_CNT(T_MAX)) u_mrd_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .start (cmd == CMD_MRS),
      .count (since_mrs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_act_ba <= '0;
      end else if (clr) begin
         last_act_ba <= '0;
      end else if (cmd == CMD_ACT) begin
         last_act_ba <= ba;
      end
   end

   sdram_refresh_window #(
      .WINDOW   (REF_WINDOW),
      .MIN_REFS (REF_MIN)
   ) u_refwin (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .ref_now (cmd == CMD_REF),
      .starve  (starve)
   );

   always_comb begin
      viol_vec = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         viol_vec = viol_vec | bank_viol[b];
      end
      viol_vec[V_RRD]    = (cmd == CMD_ACT) && (ba != last_act_ba)
                           && (since_any_act < CW'(T_RRD));
      viol_vec[V_MRD]    = is_cmd && (since_mrs < CW'(T_MRD));
      viol_vec[V_STATE]  = viol_vec[V_STATE]
                           || (((cmd == CMD_REF) || (cmd == CMD_MRS)) && any_open);
      viol_vec[V_STARVE] = starve;
   end

   // Lowest set bit wins when several rules break together
   assign first_viol = viol_vec & (~viol_vec + NUM_VIOL'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err       <= 1'b0;
         viol_code <= '0;
      end else if (clr) begin
         err       <= 1'b0;
         viol_code <= '0;
      end else if (!err && (|viol_vec)) begin
         err       <= 1'b1;
         viol_code <= first_viol;
      end
   end

   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);

   assert_code_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> $stable(viol_code));

   assert_code_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($countones(viol_code) == 1));

   assert_no_code_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !err |-> (viol_code == '0));

   assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!err && (viol_code == '0)));

endmodule

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;

   logic       clk = 1'b0;
   logic       rst_n, clr, cs_n, ras_n, cas_n, we_n, a10;
   logic [0:0] ba;
   logic       err;
   logic [7:0] viol_code;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sdram_cmd_checker #(
      .REF_WINDOW (64),
      .REF_MIN    (2)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .ba        (ba),
      .a10       (a10),
      .err       (err),
      .viol_code (viol_code)
   );

   localparam logic [2:0] E_ACT = 3'b011, E_RD = 3'b101, E_WR = 3'b100,
                          E_PRE = 3'b010, E_REF = 3'b001, E_MRS = 3'b000,
                          E_BST = 3'b110, E_NOP = 3'b111;

   task automatic bus_nop();
      cs_n = 1'b0; {ras_n, cas_n, we_n} = E_NOP; ba = 1'b0; a10 = 1'b0;
   endtask

   // Called at a falling edge; the command is sampled at the next rising edge.
   task automatic issue(input logic [2:0] enc, input logic b, input logic ap,
                        input logic desel);
      cs_n = desel; {ras_n, cas_n, we_n} = enc; ba = b; a10 = ap;
      @(negedge clk);
      bus_nop();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_clr();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic check(input string req, input logic [7:0] exp_code);
      logic exp_err;
      exp_err = (exp_code != 8'h00);
      checks++;
      if (err !== exp_err || viol_code !== exp_code) begin
         fails++;
         $display("FAIL %s: err=%0b code=%02h expected err=%0b code=%02h",
                  req, err, viol_code, exp_err, exp_code);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #4000000;
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; clr = 1'b0;
      bus_nop();
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check("R13 reset state", 8'h00);

      // R2: activate to read spacing sweep
      for (int d = 1; d <= 4; d++) begin
         do_clr();
         issue(E_ACT, 0, 0, 0); idle(d - 1); issue(E_RD, 0, 0, 0);
         check($sformatf("R2 act-rd d=%0d", d), (d < 3) ? 8'h01 : 8'h00);
      end

      // R3: precharge to activate spacing sweep
      for (int d = 1; d <= 4; d++) begin
         do_clr();
         issue(E_ACT, 0, 0, 0); idle(9); issue(E_PRE, 0, 0, 0);
         idle(d - 1); issue(E_ACT, 0, 0, 0);
         check($sformatf("R3 pre-act d=%0d", d), (d < 3) ? 8'h02 : 8'h00);
      end

      // R4: activate to precharge spacing sweep
      for (int d = 1; d <= 7; d++) begin
         do_clr();
         issue(E_ACT, 0, 0, 0); idle(d - 1); issue(E_PRE, 0, 0, 0);
         check($sformatf("R4 act-pre d=%0d", d), (d < 6) ? 8'h04 : 8'h00);
      end

      // R5 with R9 auto-close: same-bank activate spacing sweep
      for (int d = 6; d <= 10; d++) begin
         do_clr();
         issue(E_ACT, 0, 0, 0); idle(2); issue(E_RD, 0, 1, 0);
         idle(d - 4); issue(E_ACT, 0, 0, 0);
         check($sformatf("R5 act-act d=%0d", d), (d < 9) ? 8'h08 : 8'h00);
      end

      // R6: activates to different banks
      for (int d = 1; d <= 3; d++) begin
         do_clr();
         issue(E_ACT, 0, 0, 0); idle(d - 1); issue(E_ACT, 1, 0, 0);
         check($sformatf("R6 act-act other d=%0d", d), (d < 2) ? 8'h10 : 8'h00);
      end

      // R7: command after mode set
      for (int d = 1; d <= 3; d++) begin
         do_clr();
         issue(E_MRS, 0, 0, 0); idle(d - 1); issue(E_REF, 0, 0, 0);
         check($sformatf("R7 mrs-ref d=%0d", d), (d < 2) ? 8'h20 : 8'h00);
      end

      // R1: deselected bus is ignored; burst stop counts as a command
      do_clr();
      issue(E_MRS, 0, 0, 0); issue(E_ACT, 0, 0, 1);
      check("R1 deselect ignored after mode set", 8'h00);
      do_clr();
      issue(E_MRS, 0, 0, 0); issue(E_BST, 0, 0, 0);
      check("R1 burst stop is a command", 8'h20);

      // R8: state rules
      do_clr();
      issue(E_RD, 1, 0, 0);
      check("R8 read closed bank", 8'h40);
      do_clr();
      issue(E_ACT, 0, 0, 0); idle(9); issue(E_ACT, 0, 0, 0);
      check("R8 activate open bank", 8'h40);
      do_clr();
      issue(E_ACT, 1, 0, 0); idle(9); issue(E_REF, 0, 0, 0);
      check("R8 refresh while open", 8'h40);
      do_clr();
      issue(E_ACT, 0, 0, 0); idle(9); issue(E_MRS, 0, 0, 0);
      check("R8 mode set while open", 8'h40);

      // R9: precharge-all and auto-close on write
      do_clr();
      issue(E_ACT, 0, 0, 0); idle(1); issue(E_ACT, 1, 0, 0);
      idle(5); issue(E_PRE, 0, 1, 0); idle(1); issue(E_REF, 0, 0, 0);
      check("R9 precharge-all then refresh", 8'h00);
      issue(E_RD, 1, 0, 0);
      check("R9 bank 1 closed by precharge-all", 8'h40);
      do_clr();
      issue(E_ACT, 0, 0, 0); idle(2); issue(E_WR, 0, 1, 0);
      check("R9 write with auto-close legal", 8'h00);
      issue(E_RD, 0, 0, 0);
      check("R9 bank closed after auto-close write", 8'h40);

      // R11: priority and stickiness
      do_clr();
      issue(E_ACT, 0, 0, 0); issue(E_ACT, 0, 0, 0);
      check("R11 lowest bit wins", 8'h08);
      idle(2); issue(E_RD, 1, 0, 0);
      check("R11 first code held", 8'h08);

      // R12: clear
      do_clr();
      check("R12 flags cleared", 8'h00);
      issue(E_ACT, 0, 0, 0); do_clr(); issue(E_RD, 0, 0, 0);
      check("R12 bank state cleared", 8'h40);

      // R10: refresh density in a 64-cycle window, 2 required
      do_clr();
      issue(E_REF, 0, 0, 0); idle(40);
      check("R10 no flag before window end", 8'h00);
      idle(30);
      check("R10 starvation at window end", 8'h80);
      do_clr();
      issue(E_REF, 0, 0, 0); idle(3); issue(E_REF, 0, 0, 0); idle(70);
      check("R10 enough refreshes", 8'h00);

      finish_run();
   end

endmodule